// File: doc/BRIEF.md
# Mask-Aware Register Scoreboard

This block records which destination registers of a SIMT core still have writes in flight, for a core that can issue loads under partial lane masks. An issue port reserves a record and counts one outstanding write into it. A completion port retires one write. A combinational hazard port tells the issue stage whether a candidate instruction touches a register that is still reserved.

A mode input picks the tracking granularity. In legacy mode there is a single record per (warp, register), and one counter sums every outstanding write to that register. In mask-aware mode each (warp, register, lane mask) triple has its own record and counter. A completion then frees only the record of the instruction that wrote it, so one partial-mask instruction cannot release another's reservation, and no reservation is left stuck.

A completion for a co-issued secondary access names its record by the source instruction's full issue mask. A primary access names it by its own active mask. Saturation, underflow and illegal mode values are reported on error outputs.

Top module: `mask_scoreboard`

## Requirements
- R1: The mode input is encoded as 0 = legacy, 1 = mask-aware, 2 = slot-pinned and 3 = illegal. Only mode 3 drives cfgErr high. Slot-pinned tracking is not built here: in modes 2 and 3, issReady is low and completions are ignored, so they raise no error and change no state.
- R2: In mode 0 each (warp, register) pair has one record, and issues with different masks add to the same counter. issReady is always high in mode 0.
- R3: In mode 0 a record is freed only when its combined counter returns to zero. Until then, chkStall is high for that register whatever mask the probe carries.
- R4: In mode 1 an issue with a new (warp, register, mask) triple allocates a separate record. An issue whose triple is already live increments that record's counter.
- R5: In mode 1 a completion decrements the counter of its exact triple. Reaching zero frees that record only, and the other masks of the same register stay reserved.
- R6: In mode 1, chkStall is high when chkSrcA, chkSrcB or chkDst, in warp chkWarp, has a live record whose mask shares at least one bit with chkMask. It is low for disjoint masks and for other warps.
- R7: The completion's record mask is cmpSrcMask when cmpSecondary is 1, and cmpMask when cmpSecondary is 0.
- R8: In mode 1 each (warp, register) holds 4 records. issReady goes low when the offered triple is not live and all 4 records are in use. It goes high again once one of them is freed.
- R9: Counters are 4 bits wide and saturate at 15. An issue that finds its record at 15 leaves the counter at 15 and pulses ovfErr for one cycle after the accepting edge.
- R10: When an issue and a completion hit the same live record in the same cycle, the counter is left unchanged and the record is not freed.
- R11: A completion that finds no live record pulses udfErr for one cycle after its edge and changes no state.
- R12: Reset (rstN low) clears every record, and ovfErr and udfErr read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Tracking mode (0 legacy, 1 mask-aware, 2 slot-pinned, 3 illegal) |
| issValid | input | 1 | Issue request |
| issWarp | input | 3 | Issuing warp |
| issReg | input | 5 | Destination register of the issue |
| issMask | input | 32 | Active-lane mask of the issue |
| issReady | output | 1 | Issue can be accepted this cycle |
| cmpValid | input | 1 | Write completion |
| cmpWarp | input | 3 | Warp of the completing write |
| cmpReg | input | 5 | Register of the completing write |
| cmpMask | input | 32 | Own active mask of a primary access |
| cmpSecondary | input | 1 | Completion belongs to a co-issued secondary access |
| cmpSrcMask | input | 32 | Full issue mask of the source instruction |
| chkWarp | input | 3 | Warp of the candidate instruction |
| chkSrcA | input | 5 | First source register |
| chkSrcB | input | 5 | Second source register |
| chkDst | input | 5 | Destination register |
| chkMask | input | 32 | Active mask of the candidate |
| chkStall | output | 1 | Candidate overlaps a live reservation |
| cfgErr | output | 1 | Illegal mode value |
| ovfErr | output | 1 | Counter saturation pulse |
| udfErr | output | 1 | Completion without live record pulse |

## Verification
Results arrive at different times, and the checks are timed to match.

- issReady and chkStall are combinational from the stored records and the request inputs. The bench applies its request values after a falling edge and reads these outputs 1 ns later, with no clock edge in between.
- A record change made by an issue or completion becomes visible on chkStall and issReady right after the rising edge that accepts it. ovfErr and udfErr are registered, so each is due in that same post-edge interval and is gone after the next rising edge.
- The bench therefore reads error flags 1 ns after the accepting edge, and probes reservation state only at a later falling edge.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_MASK   = 2'd1,
    MODE_PINNED = 2'd2,
    MODE_BAD    = 2'd3
  } sbMode_e;

  // strobes from control to the record store
  typedef struct packed {
    logic allocEn;  // open a fresh record at the issue slot
    logic incEn;    // add one to the issue slot's counter
    logic decEn;    // take one from the completion slot's counter
    logic relEn;    // completion slot drops to zero: free it
  } sbStrobe_t;

endpackage

// File: rtl/sb_store.sv
module sb_store
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int NUM_REGS  = 32,
  parameter int SLOTS     = 4,
  parameter int MASK_W    = 32,
  parameter int CNT_W     = 4,
  localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              legacy,
  input  sbStrobe_t         strobe,
  input  logic [WARP_W-1:0] issWarp,
  input  logic [REG_W-1:0]  issReg,
  input  logic [MASK_W-1:0] issMask,
  input  logic [WARP_W-1:0] cmpWarp,
  input  logic [REG_W-1:0]  cmpReg,
  input  logic [MASK_W-1:0] relMask,
  input  logic [WARP_W-1:0] chkWarp,
  input  logic [REG_W-1:0]  chkSrcA,
  input  logic [REG_W-1:0]  chkSrcB,
  input  logic [REG_W-1:0]  chkDst,
  input  logic [MASK_W-1:0] chkMask,
  output logic              issHitAny,
  output logic              issFreeAny,
  output logic [CNT_W-1:0]  issCnt,
  output logic              cmpHitAny,
  output logic [CNT_W-1:0]  cmpCnt,
  output logic              sameEntry,
  output logic              chkStall
);

  localparam int DEPTH = NUM_WARPS * NUM_REGS * SLOTS;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              valid   [DEPTH];
  logic [MASK_W-1:0] maskMem [DEPTH];
  logic [CNT_W-1:0]  cntMem  [DEPTH];

  function automatic logic [IDX_W-1:0] entryIdx(input logic [WARP_W-1:0] w,
                                                input logic [REG_W-1:0] r,
                                                input int s);
    return IDX_W'((int'(w) * NUM_REGS + int'(r)) * SLOTS + s);
  endfunction

  logic [SLOT_W-1:0] issSlot, cmpSlot;
  logic [IDX_W-1:0]  issIdx, cmpIdx;

  // issue lookup: first matching record, otherwise first free record
  always_comb begin
    logic [SLOT_W-1:0] freeSlot;
    logic [SLOT_W-1:0] hitSlot;
    issHitAny  = 1'b0;
    issFreeAny = 1'b0;
    freeSlot   = '0;
    hitSlot    = '0;
    for (int s = 0; s < SLOTS; s++) begin
      logic [IDX_W-1:0] ix;
      logic usable;
      ix     = entryIdx(issWarp, issReg, s);
      usable = !legacy || (s == 0);
      if (usable && valid[ix] && !issHitAny &&
          (legacy || maskMem[ix] == issMask)) begin
        issHitAny = 1'b1;
        hitSlot   = SLOT_W'(s);
      end
      if (usable && !valid[ix] && !issFreeAny) begin
        issFreeAny = 1'b1;
        freeSlot   = SLOT_W'(s);
      end
    end
    issSlot = issHitAny ? hitSlot : freeSlot;
    issIdx  = entryIdx(issWarp, issReg, int'(issSlot));
    issCnt  = cntMem[issIdx];
  end

  // completion lookup by the release mask
  always_comb begin
    cmpHitAny = 1'b0;
    cmpSlot   = '0;
    for (int s = 0; s < SLOTS; s++) begin
      logic [IDX_W-1:0] ix;
      ix = entryIdx(cmpWarp, cmpReg, s);
      if ((!legacy || s == 0) && valid[ix] && !cmpHitAny &&
          (legacy || maskMem[ix] == relMask)) begin
        cmpHitAny = 1'b1;
        cmpSlot   = SLOT_W'(s);
      end
    end
    cmpIdx    = entryIdx(cmpWarp, cmpReg, int'(cmpSlot));
    cmpCnt    = cntMem[cmpIdx];
    sameEntry = issHitAny && cmpHitAny && (issIdx == cmpIdx);
  end

  // hazard probe over the three named registers
  always_comb begin
    chkStall = 1'b0;
    for (int k = 0; k < 3; k++) begin
      logic [REG_W-1:0] r;
      r = (k == 0) ? chkSrcA : ((k == 1) ? chkSrcB : chkDst);
      for (int s = 0; s < SLOTS; s++) begin
        logic [IDX_W-1:0] ix;
        ix = entryIdx(chkWarp, r, s);
        if (valid[ix] && (legacy || (|(maskMem[ix] & chkMask))))
          chkStall = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid[i]  <= 1'b0;
        cntMem[i] <= '0;
      end
    end else begin
      if (strobe.allocEn) begin
        valid[issIdx]  <= 1'b1;
        cntMem[issIdx] <= CNT_W'(1);
      end else if (strobe.incEn) begin
        cntMem[issIdx] <= cntMem[issIdx] + CNT_W'(1);
      end
      if (strobe.relEn) begin
        valid[cmpIdx]  <= 1'b0;
        cntMem[cmpIdx] <= '0;
      end else if (strobe.decEn) begin
        cntMem[cmpIdx] <= cntMem[cmpIdx] - CNT_W'(1);
      end
    end
  end

  // mask payload carries no reset; it is qualified by valid
  always_ff @(posedge clk) begin
    if (strobe.allocEn)
      maskMem[issIdx] <= legacy ? {MASK_W{1'b1}} : issMask;
  end

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             issValid,
  input  logic             cmpValid,
  input  logic             issHitAny,
  input  logic             issFreeAny,
  input  logic [CNT_W-1:0] issCnt,
  input  logic             cmpHitAny,
  input  logic [CNT_W-1:0] cmpCnt,
  input  logic             sameEntry,
  output logic             legacy,
  output logic             issReady,
  output logic             cfgErr,
  output sbStrobe_t        strobe,
  output logic             ovfErr,
  output logic             udfErr
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic modeOk, issFire, cmpFire, cmpGood, clash, ovfNext, udfNext;

  always_comb begin
    legacy   = (mode == MODE_LEGACY);
    modeOk   = (mode == MODE_LEGACY) || (mode == MODE_MASK);
    cfgErr   = (mode == MODE_BAD);
    issReady = modeOk && (issHitAny || issFreeAny);
    issFire  = issValid && issReady;
    cmpFire  = cmpValid && modeOk;
    cmpGood  = cmpFire && cmpHitAny && (cmpCnt != '0);
    clash    = issFire && cmpGood && sameEntry;

    strobe.allocEn = issFire && !issHitAny;
    strobe.incEn   = issFire && issHitAny && !clash && (issCnt != CNT_MAX);
    strobe.decEn   = cmpGood && !clash;
    strobe.relEn   = cmpGood && !clash && (cmpCnt == CNT_W'(1));

    ovfNext = issFire && issHitAny && !clash && (issCnt == CNT_MAX);
    udfNext = cmpFire && !cmpGood;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfErr <= 1'b0;
      udfErr <= 1'b0;
    end else begin
      ovfErr <= ovfNext;
      udfErr <= udfNext;
    end
  end

endmodule

// File: rtl/mask_scoreboard.sv
module mask_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int NUM_REGS  = 32,
  parameter int SLOTS     = 4,
  parameter int MASK_W    = 32,
  parameter int CNT_W     = 4,
  localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              issValid,
  input  logic [WARP_W-1:0] issWarp,
  input  logic [REG_W-1:0]  issReg,
  input  logic [MASK_W-1:0] issMask,
  output logic              issReady,
  input  logic              cmpValid,
  input  logic [WARP_W-1:0] cmpWarp,
  input  logic [REG_W-1:0]  cmpReg,
  input  logic [MASK_W-1:0] cmpMask,
  input  logic              cmpSecondary,
  input  logic [MASK_W-1:0] cmpSrcMask,
  input  logic [WARP_W-1:0] chkWarp,
  input  logic [REG_W-1:0]  chkSrcA,
  input  logic [REG_W-1:0]  chkSrcB,
  input  logic [REG_W-1:0]  chkDst,
  input  logic [MASK_W-1:0] chkMask,
  output logic              chkStall,
  output logic              cfgErr,
  output logic              ovfErr,
  output logic              udfErr
);

  sbStrobe_t        strobe;
  logic             legacy, issHitAny, issFreeAny, cmpHitAny, sameEntry;
  logic [CNT_W-1:0] issCnt, cmpCnt;
  logic [MASK_W-1:0] relMask;

  assign relMask = cmpSecondary ? cmpSrcMask : cmpMask;

  sb_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode),
    .issValid(issValid), .cmpValid(cmpValid),
    .issHitAny(issHitAny), .issFreeAny(issFreeAny), .issCnt(issCnt),
    .cmpHitAny(cmpHitAny), .cmpCnt(cmpCnt), .sameEntry(sameEntry),
    .legacy(legacy), .issReady(issReady), .cfgErr(cfgErr),
    .strobe(strobe), .ovfErr(ovfErr), .udfErr(udfErr)
  );

  sb_store #(
    .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .SLOTS(SLOTS),
    .MASK_W(MASK_W), .CNT_W(CNT_W)
  ) store_i (
    .clk(clk), .rstN(rstN), .legacy(legacy), .strobe(strobe),
    .issWarp(issWarp), .issReg(issReg), .issMask(issMask),
    .cmpWarp(cmpWarp), .cmpReg(cmpReg), .relMask(relMask),
    .chkWarp(chkWarp), .chkSrcA(chkSrcA), .chkSrcB(chkSrcB),
    .chkDst(chkDst), .chkMask(chkMask),
    .issHitAny(issHitAny), .issFreeAny(issFreeAny), .issCnt(issCnt),
    .cmpHitAny(cmpHitAny), .cmpCnt(cmpCnt), .sameEntry(sameEntry),
    .chkStall(chkStall)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int WARP_W = 3,
  parameter int REG_W  = 5,
  parameter int MASK_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        mode,
  input logic              issValid,
  input logic [WARP_W-1:0] issWarp,
  input logic [REG_W-1:0]  issReg,
  input logic [MASK_W-1:0] issMask,
  input logic              issReady,
  input logic              cmpValid,
  input logic [WARP_W-1:0] chkWarp,
  input logic [REG_W-1:0]  chkDst,
  input logic [MASK_W-1:0] chkMask,
  input logic              chkStall,
  input logic              ovfErr,
  input logic              udfErr
);

  // R1: pinned and illegal modes never accept an issue
  a_r1_no_issue_off_mode: assert property (@(posedge clk) disable iff (!rstN)
    (mode >= 2'd2) |-> !issReady);

  // R2: legacy mode always has its single record available
  a_r2_legacy_ready: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |-> issReady);

  // R6: a fresh mask-aware issue is visible to an overlapping probe
  a_r6_stall_after_issue: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 2'd1) && ($past(mode) == 2'd1) && $past(issValid && issReady) &&
     !$past(cmpValid) && (chkWarp == $past(issWarp)) && (chkDst == $past(issReg)) &&
     ((chkMask & $past(issMask)) != '0)) |-> chkStall);

  // R9: saturation is only flagged after an accepted issue
  a_r9_ovf_source: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |-> $past(issValid && issReady));

  // R11: underflow is only flagged after a completion in an active mode
  a_r11_udf_source: assert property (@(posedge clk) disable iff (!rstN)
    udfErr |-> ($past(cmpValid) && ($past(mode) < 2'd2)));

  // R12: error flags are clear as reset is released
  a_r12_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!ovfErr && !udfErr));

endmodule

bind mask_scoreboard sb_checker #(.WARP_W(WARP_W), .REG_W(REG_W), .MASK_W(MASK_W)) chk_i (
  .clk(clk), .rstN(rstN), .mode(mode), .issValid(issValid), .issWarp(issWarp),
  .issReg(issReg), .issMask(issMask), .issReady(issReady), .cmpValid(cmpValid),
  .chkWarp(chkWarp), .chkDst(chkDst), .chkMask(chkMask), .chkStall(chkStall),
  .ovfErr(ovfErr), .udfErr(udfErr)
);

// File: tb/mask_scoreboard_tb.sv
`timescale 1ns/1ps
module mask_scoreboard_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        issValid = 1'b0;
  logic [2:0]  issWarp = '0;
  logic [4:0]  issReg = '0;
  logic [31:0] issMask = '0;
  logic        issReady;
  logic        cmpValid = 1'b0;
  logic [2:0]  cmpWarp = '0;
  logic [4:0]  cmpReg = '0;
  logic [31:0] cmpMask = '0;
  logic        cmpSecondary = 1'b0;
  logic [31:0] cmpSrcMask = '0;
  logic [2:0]  chkWarp = '0;
  logic [4:0]  chkSrcA = '0, chkSrcB = '0, chkDst = '0;
  logic [31:0] chkMask = '0;
  logic        chkStall, cfgErr, ovfErr, udfErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mask_scoreboard dut_i (
    .clk(clk), .rstN(rstN), .mode(mode),
    .issValid(issValid), .issWarp(issWarp), .issReg(issReg), .issMask(issMask),
    .issReady(issReady),
    .cmpValid(cmpValid), .cmpWarp(cmpWarp), .cmpReg(cmpReg), .cmpMask(cmpMask),
    .cmpSecondary(cmpSecondary), .cmpSrcMask(cmpSrcMask),
    .chkWarp(chkWarp), .chkSrcA(chkSrcA), .chkSrcB(chkSrcB), .chkDst(chkDst),
    .chkMask(chkMask), .chkStall(chkStall),
    .cfgErr(cfgErr), .ovfErr(ovfErr), .udfErr(udfErr)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doIssue(input int w, input int r, input logic [31:0] m);
    @(negedge clk);
    issValid = 1'b1; issWarp = 3'(w); issReg = 5'(r); issMask = m;
    @(posedge clk); #1;
    issValid = 1'b0;
  endtask

  task automatic doCmp(input int w, input int r, input logic [31:0] m,
                       input bit sec, input logic [31:0] src);
    @(negedge clk);
    cmpValid = 1'b1; cmpWarp = 3'(w); cmpReg = 5'(r); cmpMask = m;
    cmpSecondary = sec; cmpSrcMask = src;
    @(posedge clk); #1;
    cmpValid = 1'b0; cmpSecondary = 1'b0;
  endtask

  task automatic doBoth(input int w, input int r, input logic [31:0] m);
    @(negedge clk);
    issValid = 1'b1; issWarp = 3'(w); issReg = 5'(r); issMask = m;
    cmpValid = 1'b1; cmpWarp = 3'(w); cmpReg = 5'(r); cmpMask = m; cmpSecondary = 1'b0;
    @(posedge clk); #1;
    issValid = 1'b0; cmpValid = 1'b0;
  endtask

  task automatic probe(input int w, input int a, input int b, input int d,
                       input logic [31:0] m, output logic st);
    @(negedge clk);
    chkWarp = 3'(w); chkSrcA = 5'(a); chkSrcB = 5'(b); chkDst = 5'(d); chkMask = m;
    #1;
    st = chkStall;
  endtask

  task automatic readyFor(input int w, input int r, input logic [31:0] m, output logic rd);
    @(negedge clk);
    issWarp = 3'(w); issReg = 5'(r); issMask = m;
    #1;
    rd = issReady;
  endtask

  initial begin : watchdog
    #(150000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic st, rd;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R12: clean state out of reset
    checkEq("R12 ovfErr after reset", 32'(ovfErr), 0);
    checkEq("R12 udfErr after reset", 32'(udfErr), 0);
    checkEq("R2 issReady in mode 0", 32'(issReady), 1);
    probe(0, 0, 0, 0, 32'hFFFF_FFFF, st);
    checkEq("R12 no stall after reset", 32'(st), 0);

    // R1: mode encodings
    @(negedge clk); mode = 2'd3; #1;
    checkEq("R1 cfgErr in mode 3", 32'(cfgErr), 1);
    checkEq("R1 issReady low in mode 3", 32'(issReady), 0);
    @(negedge clk); mode = 2'd2; #1;
    checkEq("R1 cfgErr low in mode 2", 32'(cfgErr), 0);
    doIssue(4, 4, 32'h1);
    doCmp(4, 4, 32'h2, 1'b0, 32'h0);
    checkEq("R1 completion ignored in mode 2", 32'(udfErr), 0);
    @(negedge clk); mode = 2'd1; #1;
    checkEq("R1 cfgErr low in mode 1", 32'(cfgErr), 0);
    probe(4, 4, 4, 4, 32'hFFFF_FFFF, st);
    checkEq("R1 mode-2 issue not recorded", 32'(st), 0);

    // R2/R3: legacy sweep over every warp and register
    @(negedge clk); mode = 2'd0;
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 32; r++) begin
        doIssue(w, r, 32'(1) << ((w + r) % 32));
        checkEq("R2 legacy issue no ovf", 32'(ovfErr), 0);
      end
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 32; r++) begin
        probe(w, r, r, r, 32'h0, st);
        checkEq($sformatf("R3 legacy stall w%0d r%0d", w, r), 32'(st), 1);
      end
    doIssue(3, 5, 32'h8000_0000);
    checkEq("R2 legacy ready stays high", 32'(issReady), 1);
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 32; r++) begin
        doCmp(w, r, 32'h1234, 1'b0, 32'h0);
        checkEq("R2 legacy completion no udf", 32'(udfErr), 0);
      end
    probe(3, 5, 5, 5, 32'h0, st);
    checkEq("R3 aggregate count still held", 32'(st), 1);
    probe(3, 6, 6, 6, 32'hFFFF_FFFF, st);
    checkEq("R3 neighbour freed", 32'(st), 0);
    doCmp(3, 5, 32'h0, 1'b0, 32'h0);
    probe(3, 5, 5, 5, 32'hFFFF_FFFF, st);
    checkEq("R3 freed at zero", 32'(st), 0);

    // R4/R5/R6: mask-aware records
    @(negedge clk); mode = 2'd1;
    doIssue(1, 4, 32'h0000_00FF);
    doIssue(1, 4, 32'h0000_00FF);
    doIssue(1, 4, 32'h0000_FF00);
    probe(1, 30, 30, 4, 32'h00FF_0000, st);
    checkEq("R6 disjoint mask no stall", 32'(st), 0);
    probe(1, 30, 30, 4, 32'h0000_0100, st);
    checkEq("R6 dst overlap stalls", 32'(st), 1);
    probe(1, 4, 30, 30, 32'h0000_0001, st);
    checkEq("R6 srcA overlap stalls", 32'(st), 1);
    probe(1, 30, 4, 30, 32'h0000_8000, st);
    checkEq("R6 srcB overlap stalls", 32'(st), 1);
    probe(2, 4, 4, 4, 32'hFFFF_FFFF, st);
    checkEq("R6 other warp no stall", 32'(st), 0);
    doCmp(1, 4, 32'h0000_FF00, 1'b0, 32'h0);
    checkEq("R5 completion no udf", 32'(udfErr), 0);
    probe(1, 30, 30, 4, 32'h0000_0100, st);
    checkEq("R5 own mask freed", 32'(st), 0);
    probe(1, 30, 30, 4, 32'h0000_0001, st);
    checkEq("R5 other mask kept", 32'(st), 1);
    doCmp(1, 4, 32'h0000_00FF, 1'b0, 32'h0);
    probe(1, 30, 30, 4, 32'h0000_0001, st);
    checkEq("R4 shared record counted twice", 32'(st), 1);
    doCmp(1, 4, 32'h0000_00FF, 1'b0, 32'h0);
    probe(1, 30, 30, 4, 32'hFFFF_FFFF, st);
    checkEq("R5 last mask freed", 32'(st), 0);

    // R7/R11: release mask selection and underflow
    doIssue(0, 1, 32'h0000_00F0);
    doCmp(0, 1, 32'h0000_000F, 1'b1, 32'h0000_00F0);
    checkEq("R7 secondary uses source mask", 32'(udfErr), 0);
    probe(0, 1, 1, 1, 32'hFFFF_FFFF, st);
    checkEq("R7 secondary release freed", 32'(st), 0);
    doCmp(0, 1, 32'h0000_00F0, 1'b0, 32'h0);
    checkEq("R11 absent record underflow", 32'(udfErr), 1);
    @(posedge clk); #1;
    checkEq("R11 underflow is a pulse", 32'(udfErr), 0);
    doIssue(0, 1, 32'h0000_000F);
    doCmp(0, 1, 32'h0000_000F, 1'b1, 32'h0000_0003);
    checkEq("R7 secondary ignores own mask", 32'(udfErr), 1);
    probe(0, 1, 1, 1, 32'h0000_000F, st);
    checkEq("R11 state unchanged on underflow", 32'(st), 1);
    doCmp(0, 1, 32'h0000_000F, 1'b0, 32'h0);
    checkEq("R7 primary uses own mask", 32'(udfErr), 0);

    // R8: four records per register
    for (int k = 0; k < 4; k++) begin
      readyFor(5, 7, 32'(1) << k, rd);
      checkEq("R8 ready while slots free", 32'(rd), 1);
      doIssue(5, 7, 32'(1) << k);
    end
    readyFor(5, 7, 32'h10, rd);
    checkEq("R8 full rejects new mask", 32'(rd), 0);
    readyFor(5, 7, 32'h1, rd);
    checkEq("R8 full accepts live mask", 32'(rd), 1);
    readyFor(5, 8, 32'h10, rd);
    checkEq("R8 other register unaffected", 32'(rd), 1);
    doCmp(5, 7, 32'h2, 1'b0, 32'h0);
    readyFor(5, 7, 32'h10, rd);
    checkEq("R8 freed slot restores ready", 32'(rd), 1);

    // R9: saturation at 15
    for (int k = 0; k < 15; k++) begin
      doIssue(6, 9, 32'hAAAA);
      checkEq("R9 no ovf below max", 32'(ovfErr), 0);
    end
    doIssue(6, 9, 32'hAAAA);
    checkEq("R9 ovf at saturation", 32'(ovfErr), 1);
    for (int k = 0; k < 14; k++) doCmp(6, 9, 32'hAAAA, 1'b0, 32'h0);
    probe(6, 9, 9, 9, 32'h2, st);
    checkEq("R9 held after 14 completions", 32'(st), 1);
    doCmp(6, 9, 32'hAAAA, 1'b0, 32'h0);
    probe(6, 9, 9, 9, 32'h2, st);
    checkEq("R9 freed after 15 completions", 32'(st), 0);

    // R10: same-cycle issue and completion
    doIssue(7, 2, 32'h1);
    doBoth(7, 2, 32'h1);
    checkEq("R10 no udf on overlap", 32'(udfErr), 0);
    probe(7, 2, 2, 2, 32'h1, st);
    checkEq("R10 record kept", 32'(st), 1);
    doCmp(7, 2, 32'h1, 1'b0, 32'h0);
    probe(7, 2, 2, 2, 32'h1, st);
    checkEq("R10 count was unchanged", 32'(st), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule